// File: doc/BRIEF.md
# ARINC 429 Word Acceptance Filter and Host Readout

This block sits behind an ARINC 429 serial receiver. The receiver assembles a 32-bit word and pulses an end-of-sequence strobe once it has the whole word. The block checks the word's parity. In the stored copy, the top bit is replaced by a flag that shows whether parity was bad. If the label decoder is turned on, the block compares two bits of the word against two programmed control bits and drops words that do not match.

An accepted word is held in a latch, and an active-low data-ready output tells the host that a word is waiting. The host reads the word through a 16-bit port in two halves, using an active-low enable and a half-select line. A read counts when the enable is released. Once both halves have been read since the latest word arrived, in either order, data-ready is released. A newer accepted word overwrites an unread one and starts the read record again.

Top module: `wfr_top`

## Requirements
- R1: Bit 31 of the latched word is 0 when the received 32-bit word has an odd number of ones, and 1 when that number is even.
- R2: Bits 30 down to 0 of the latched word equal bits 30 down to 0 of the received word.
- R3: With `decodeEn` high, a word is accepted only when `rxWord[8]` equals `matchBits[0]` and `rxWord[9]` equals `matchBits[1]`.
- R4: With `decodeEn` low, every word presented with `rxEos` is accepted.
- R5: When `rxEos` is high with an accepted word at a clock edge, the latch loads at that edge and `dataReadyN` is low after it.
- R6: While `hostEnN` is low, `hostData` shows latched bits 15:0 when `halfSel` is 0 and bits 31:16 when `halfSel` is 1.
- R7: A half counts as read at the first clock edge that samples `hostEnN` high after it was low, using the select that was held while enabled. `dataReadyN` goes high only after both halves have been read since the latest load, in either order. One half alone does not release it.
- R8: A new accepted word before both halves are read replaces the latched word and clears the record of halves already read.
- R9: If a load and the completing half-read fall on the same edge, the new word is latched and `dataReadyN` stays low.
- R10: A rejected word leaves the latched word and `dataReadyN` unchanged.
- R11: While `hostEnN` is high, `hostData` is all zeros (or high-impedance when `TRISTATE` is 1).
- R12: After reset, `dataReadyN` is high, the latch holds zero, and no half is marked as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxWord | input | 32 | Assembled word from the bit receiver; bit 0 is the first bit on the line |
| rxEos | input | 1 | End-of-sequence strobe, one cycle per word |
| decodeEn | input | 1 | Turns on the two-bit field compare |
| matchBits | input | 2 | Programmed values compared with word bits 9 and 8 |
| hostEnN | input | 1 | Active-low host read enable |
| halfSel | input | 1 | 0 selects the lower half, 1 selects the upper half |
| hostData | output | 16 | Selected half of the latched word |
| dataReadyN | output | 1 | Active-low indication that an unread word is held |

## Verification
The assertions assume that `rxEos` is a single-cycle pulse and that `rxWord`, `decodeEn` and `matchBits` are steady at the edge that samples it. They also assume that `hostEnN` stays low for at least one clock edge, so the held select is valid when the release is seen. The bench changes every input only on the falling clock edge. Each word is strobed for exactly one cycle, and each enable window is held low across one full rising edge before release. Same-edge cases are built on purpose by releasing the enable in the very cycle that carries the strobe.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
  typedef struct packed {
    logic load;   // capture the incoming word into the latch
    logic drive;  // host port is enabled
    logic upper;  // host selects the upper half
  } wfrStrobes_t;
endpackage

// File: rtl/wfr_ctrl.sv
module wfr_ctrl
  import wfr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEos,
  input  logic        matchOk,
  input  logic        hostEnN,
  input  logic        halfSel,
  output wfrStrobes_t strobes,
  output logic        dataReadyN
);
  logic enPrevN;
  logic selHeld;
  logic loDone;
  logic hiDone;
  logic accept;
  logic rel;
  logic nextLo;
  logic nextHi;

  assign accept = rxEos & matchOk;
  assign rel    = hostEnN & ~enPrevN;
  assign nextLo = loDone | (rel & ~selHeld);
  assign nextHi = hiDone | (rel & selHeld);

  always_comb begin
    strobes.load  = accept;
    strobes.drive = ~hostEnN;
    strobes.upper = halfSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrevN <= 1'b1;
      selHeld <= 1'b0;
    end else begin
      enPrevN <= hostEnN;
      if (!hostEnN) selHeld <= halfSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loDone     <= 1'b0;
      hiDone     <= 1'b0;
      dataReadyN <= 1'b1;
    end else if (accept) begin
      loDone     <= 1'b0;
      hiDone     <= 1'b0;
      dataReadyN <= 1'b0;
    end else if (rel) begin
      if (nextLo && nextHi) begin
        loDone     <= 1'b0;
        hiDone     <= 1'b0;
        dataReadyN <= 1'b1;
      end else begin
        loDone <= nextLo;
        hiDone <= nextHi;
      end
    end
  end

  // R5 / R9: an accepted word always leaves data-ready asserted
  a_r5_accept_sets_ready: assert property (@(posedge clk) disable iff (!rstN)
    (rxEos && matchOk) |=> !dataReadyN);

  // R10: without an acceptance or a completed read nothing moves data-ready
  a_r10_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!(rxEos && matchOk) && !(hostEnN && !enPrevN)) |=> $stable(dataReadyN));

  // R7: data-ready is only released by a finished read
  a_r7_release_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReadyN) |-> $past(hostEnN && !enPrevN));
endmodule

// File: rtl/wfr_dpath.sv
module wfr_dpath
  import wfr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MATCH_LSB = 8,
  parameter bit TRISTATE  = 1'b0,
  localparam int HALF_W   = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              decodeEn,
  input  logic [1:0]        matchBits,
  input  wfrStrobes_t       strobes,
  output logic              matchOk,
  output logic [HALF_W-1:0] hostData
);
  logic [WORD_W-1:0] latchWord;
  logic              parityErr;
  logic [HALF_W-1:0] halfMux;

  assign matchOk   = ~decodeEn | (rxWord[MATCH_LSB +: 2] == matchBits);
  assign parityErr = ~(^rxWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchWord <= '0;
    else if (strobes.load) latchWord <= {parityErr, rxWord[WORD_W-2:0]};
  end

  assign halfMux = strobes.upper ? latchWord[WORD_W-1:HALF_W] : latchWord[HALF_W-1:0];

  generate
    if (TRISTATE) begin : g_bus_z
      assign hostData = strobes.drive ? halfMux : {HALF_W{1'bz}};
    end else begin : g_bus_zero
      assign hostData = strobes.drive ? halfMux : '0;
    end
  endgenerate

  // R10 / R8: the latch only changes on a load strobe
  a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(latchWord));

  // R1: the stored top bit flags an even-parity word
  a_r1_parity_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (latchWord[WORD_W-1] == !$past(^rxWord)));
endmodule

// File: rtl/wfr_top.sv
module wfr_top
  import wfr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MATCH_LSB = 8,
  parameter bit TRISTATE  = 1'b0,
  localparam int HALF_W   = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxEos,
  input  logic              decodeEn,
  input  logic [1:0]        matchBits,
  input  logic              hostEnN,
  input  logic              halfSel,
  output logic [HALF_W-1:0] hostData,
  output logic              dataReadyN
);
  wfrStrobes_t strobes;
  logic        matchOk;

  wfr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEos(rxEos), .matchOk(matchOk),
    .hostEnN(hostEnN), .halfSel(halfSel), .strobes(strobes),
    .dataReadyN(dataReadyN)
  );

  wfr_dpath #(.WORD_W(WORD_W), .MATCH_LSB(MATCH_LSB), .TRISTATE(TRISTATE)) u_dpath (
    .clk(clk), .rstN(rstN), .rxWord(rxWord), .decodeEn(decodeEn),
    .matchBits(matchBits), .strobes(strobes), .matchOk(matchOk),
    .hostData(hostData)
  );
endmodule

// File: tb/wfr_top_tb.sv
`timescale 1ns/1ps
module wfr_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] rxWord = '0;
  logic        rxEos = 1'b0;
  logic        decodeEn = 1'b0;
  logic [1:0]  matchBits = '0;
  logic        hostEnN = 1'b1;
  logic        halfSel = 1'b0;
  logic [15:0] hostData;
  logic        dataReadyN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wfr_top u_dut (
    .clk(clk), .rstN(rstN), .rxWord(rxWord), .rxEos(rxEos),
    .decodeEn(decodeEn), .matchBits(matchBits), .hostEnN(hostEnN),
    .halfSel(halfSel), .hostData(hostData), .dataReadyN(dataReadyN)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        dec;
    logic [1:0]  match;
    logic        accept;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0001, 1'b0, 2'b00, 1'b1},  // R4, odd parity
    '{32'h0000_0003, 1'b0, 2'b00, 1'b1},  // R4, even parity
    '{32'hFFFF_FFFF, 1'b0, 2'b11, 1'b1},  // R4, even parity
    '{32'h0000_0300, 1'b1, 2'b11, 1'b1},  // R3 match
    '{32'h0000_0100, 1'b1, 2'b10, 1'b0},  // R3 mismatch
    '{32'h0000_0200, 1'b1, 2'b10, 1'b1},  // R3 match
    '{32'h8000_0200, 1'b1, 2'b01, 1'b0},  // R3 mismatch
    '{32'hA5A5_5A5A, 1'b1, 2'b10, 1'b1}   // R3 match
  };

  function automatic logic [31:0] expStore(input logic [31:0] w);
    return {~(^w), w[30:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [31:0] w);
    rxWord = w;
    rxEos = 1'b1;
    tick();
    rxEos = 1'b0;
  endtask

  task automatic readHalf(input logic sel, output logic [15:0] d);
    hostEnN = 1'b0;
    halfSel = sel;
    tick();
    d = hostData;
    hostEnN = 1'b1;
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] model;
    logic [15:0] lo;
    logic [15:0] hi;
    model = '0;
    tick();
    tick();
    check("R12 ready after reset", {31'b0, dataReadyN}, 32'd1);
    check("R11 idle bus at reset", {16'b0, hostData}, 32'd0);
    rstN = 1'b1;
    tick();
    readHalf(1'b0, lo);
    readHalf(1'b1, hi);
    check("R12 latch zero after reset", {hi, lo}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      decodeEn = VECS[i].dec;
      matchBits = VECS[i].match;
      sendWord(VECS[i].word);
      if (VECS[i].accept) model = expStore(VECS[i].word);
      check(VECS[i].accept ? "R5 ready on accept" : "R10 ready unchanged on reject",
            {31'b0, dataReadyN}, {31'b0, ~VECS[i].accept});
      check("R11 bus idle", {16'b0, hostData}, 32'd0);
      readHalf(1'b0, lo);
      readHalf(1'b1, hi);
      check("R1 R2 R6 latched word", {hi, lo}, model);
      check("R7 released after both halves", {31'b0, dataReadyN}, 32'd1);
    end

    decodeEn = 1'b0;
    // R7: upper first, one half alone keeps data-ready low
    sendWord(32'h1234_5678);
    model = expStore(32'h1234_5678);
    readHalf(1'b1, hi);
    check("R7 one half keeps ready", {31'b0, dataReadyN}, 32'd0);
    readHalf(1'b1, hi);
    check("R7 same half twice keeps ready", {31'b0, dataReadyN}, 32'd0);
    readHalf(1'b0, lo);
    check("R7 reverse order releases", {31'b0, dataReadyN}, 32'd1);
    check("R6 reverse order data", {hi, lo}, model);

    // R8: overwrite clears the read record
    sendWord(32'h0F0F_0001);
    readHalf(1'b0, lo);
    sendWord(32'hC0DE_0007);
    model = expStore(32'hC0DE_0007);
    readHalf(1'b1, hi);
    check("R8 old low read forgotten", {31'b0, dataReadyN}, 32'd0);
    readHalf(1'b0, lo);
    check("R8 released after fresh halves", {31'b0, dataReadyN}, 32'd1);
    check("R8 new word latched", {hi, lo}, model);

    // R9: completing read and load on the same edge
    sendWord(32'h0000_0011);
    readHalf(1'b0, lo);
    hostEnN = 1'b0;
    halfSel = 1'b1;
    tick();
    hostEnN = 1'b1;
    rxWord = 32'h7777_8888;
    rxEos = 1'b1;
    tick();
    rxEos = 1'b0;
    model = expStore(32'h7777_8888);
    check("R9 ready stays low", {31'b0, dataReadyN}, 32'd0);
    readHalf(1'b0, lo);
    check("R9 ready after only low half", {31'b0, dataReadyN}, 32'd0);
    readHalf(1'b1, hi);
    check("R9 new word wins", {hi, lo}, model);

    // R10: rejected word with a word pending
    decodeEn = 1'b1;
    matchBits = 2'b00;
    sendWord(32'h0000_0055);
    model = expStore(32'h0000_0055);
    sendWord(32'hFFFF_0300);
    check("R10 ready kept on reject", {31'b0, dataReadyN}, 32'd0);
    readHalf(1'b0, lo);
    readHalf(1'b1, hi);
    check("R10 latch kept on reject", {hi, lo}, model);

    // R11: live select changes do nothing while disabled
    halfSel = 1'b1;
    tick();
    check("R11 bus zero when disabled", {16'b0, hostData}, 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule